// File: doc/BRIEF.md
# Full-Frame Survivor Traceback for a 256-State Trellis

This block sits after the add-compare-select stage of a rate-agnostic, constraint-length-9 convolutional decoder. On every trellis step it takes one survivor decision bit for each of the 256 states and writes the whole vector into a step-indexed store. The store is read back as a table of back-pointers.

When the frame's last step arrives, the block walks the trellis backwards. It starts from state 0, because the encoder is flushed with zero tail bits, and reads one step per cycle. It collects one decoded bit per step. It then streams the data bits out in transmit order, drops the tail, and pulses a done flag. The done flag carries a path-error flag if the walk did not arrive back at state 0.

While the walk and the output phase run, the block reports busy and discards any incoming decisions.

Top module: `trellis_traceback`

## Requirements
- R1: After reset, busy, out_valid, done and path_err are all low.
- R2: While not busy, every cycle with dec_valid high stores dec_bits as the next trellis step. Bit i of dec_bits is the decision of state i. dec_valid together with frame_end marks the last step of the frame. A frame that reaches MAX_STEPS steps ends on its own. A frame holds L steps, with MEM_BITS+1 <= L <= MAX_STEPS.
- R3: The walk starts in state 0 at the last step. From step k and state s it moves to the state {s[MEM_BITS-2:0], d}, where d is bit s of the vector stored for step k.
- R4: The decoded bit for step k is the most significant bit of the state held at step k.
- R5: The block emits exactly L-MEM_BITS bits, with out_valid high on consecutive cycles, in step order 0, 1, 2 and so on. The last MEM_BITS steps (the tail) are not emitted.
- R6: done is a one-cycle pulse in the cycle after the last output bit. path_err is high in that cycle exactly when the state reached after step 0 is not 0. Otherwise path_err is low.
- R7: busy rises in the cycle after the last step is accepted and stays high until done. Decision inputs that arrive while busy is high are ignored and do not alter the frame being decoded.
- R8: If the last step is accepted at clock edge E, the first output bit is valid after edge E+L, and done is high after edge E+2L-MEM_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_valid | input | 1 | Decision vector valid |
| dec_bits | input | 256 | Survivor decision per state |
| frame_end | input | 1 | Marks the current vector as the frame's last step |
| busy | output | 1 | Traceback or output phase in progress |
| out_valid | output | 1 | Decoded bit valid |
| out_bit | output | 1 | Decoded data bit |
| done | output | 1 | One-cycle end-of-frame pulse |
| path_err | output | 1 | Walk did not end in state 0, valid with done |

## Verification
Once the last step is accepted, the walk takes exactly L cycles. The first decoded bit is therefore due L+1 falling edges after the accepting edge, counting that edge's own falling edge as the first. The bits follow on consecutive cycles, and done falls due at count 2L-7.

The bench counts falling edges from the accepting edge. It checks the first out_valid and the done pulse against these two exact counts. All values are sampled on falling edges, so every register on the path has settled.

Garbage decision vectors are driven with frame_end during the walk. The bit-exact output must still match, which shows that those inputs were ignored.

// File: rtl/trellis_traceback.sv
module trellis_traceback #(
  parameter int MEM_BITS  = 8,
  parameter int MAX_STEPS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic [(1<<MEM_BITS)-1:0] dec_bits,
  input  logic                     frame_end,
  output logic                     busy,
  output logic                     out_valid,
  output logic                     out_bit,
  output logic                     done,
  output logic                     path_err
);
  localparam int NS = 1 << MEM_BITS;
  localparam int AW = $clog2(MAX_STEPS);
  localparam int LW = $clog2(MAX_STEPS + 1);

  typedef enum logic [1:0] {IDLE, TRACE, EMIT} st_t;
  st_t st;

  logic [NS-1:0]        surv [MAX_STEPS];
  logic [AW-1:0]        wptr, k, oidx;
  logic [LW-1:0]        len;
  logic [MEM_BITS-1:0]  cur;
  logic [MAX_STEPS-1:0] obuf;

  wire take = (st == IDLE) && dec_valid;
  wire last = take && (frame_end || wptr == AW'(MAX_STEPS - 1));
  wire sbit = surv[k][cur];
  wire [MEM_BITS-1:0] prev = {cur[MEM_BITS-2:0], sbit};

  assign busy      = (st != IDLE);
  assign out_valid = (st == EMIT);
  assign out_bit   = obuf[oidx];

  always_ff @(posedge clk)
    if (take) surv[wptr] <= dec_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; wptr <= '0; k <= '0; oidx <= '0; len <= '0;
      cur <= '0; obuf <= '0; done <= 1'b0; path_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      path_err <= 1'b0;
      case (st)
        IDLE: if (take) begin
          wptr <= last ? '0 : wptr + 1'b1;
          if (last) begin
            st  <= TRACE;
            k   <= wptr;
            len <= LW'(wptr) + 1'b1;
            cur <= '0;
          end
        end
        TRACE: begin
          obuf[k] <= cur[MEM_BITS-1];
          cur     <= prev;
          k       <= k - 1'b1;
          if (k == '0) begin
            oidx <= '0;
            if (len > LW'(MEM_BITS)) st <= EMIT;
            else begin
              st <= IDLE; done <= 1'b1; path_err <= (prev != '0);
            end
          end
        end
        EMIT: begin
          oidx <= oidx + 1'b1;
          if (LW'(oidx) == len - LW'(MEM_BITS) - 1'b1) begin
            st <= IDLE; done <= 1'b1; path_err <= (cur != '0);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  AST_TRACE_START:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(dec_valid)); // R2
  AST_OUT_CONTIG:   assert property (@(posedge clk) disable iff (!rst_n) $fell(out_valid) |-> done); // R5
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) path_err |-> done); // R6
  AST_VALID_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> busy); // R7
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R7
endmodule

// File: tb/test_trellis_traceback.sv
`timescale 1ns/1ps
module test_trellis_traceback;
  localparam int MB = 8;
  localparam int NS = 256;
  localparam int MS = 64;

  logic clk = 0, rst_n = 0;
  logic dec_valid = 0, frame_end = 0;
  logic [NS-1:0] dec_bits = '0;
  logic busy, out_valid, out_bit, done, path_err;

  int checks = 0, errors = 0;
  logic [NS-1:0] fr [MS];
  logic exp_b [MS];
  logic exp_err;

  always #2.5 clk = ~clk;

  trellis_traceback #(.MEM_BITS(MB), .MAX_STEPS(MS)) i_trellis_traceback (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_bits(dec_bits),
    .frame_end(frame_end), .busy(busy), .out_valid(out_valid), .out_bit(out_bit),
    .done(done), .path_err(path_err));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [NS-1:0] rnd_vec();
    logic [NS-1:0] v;
    for (int w = 0; w < NS/32; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  // encoded path: new bit enters at state MSB, previous state LSB is the decision
  task automatic build_path(input int L);
    logic [MB-1:0] s = '0, sn;
    for (int t = 0; t < L; t++) begin
      logic u = (t < L - MB) ? 1'($urandom) : 1'b0;
      sn = {u, s[MB-1:1]};
      fr[t] = rnd_vec();
      fr[t][sn] = s[0];
      exp_b[t] = u;
      s = sn;
    end
    exp_err = 1'b0;
  endtask

  // random decisions: expected values from the walk rule of R3 and R4
  task automatic build_random(input int L);
    logic [MB-1:0] c = '0;
    for (int t = 0; t < L; t++) fr[t] = rnd_vec();
    for (int k = L - 1; k >= 0; k--) begin
      exp_b[k] = c[MB-1];
      c = {c[MB-2:0], fr[k][c]};
    end
    exp_err = (c != '0);
  endtask

  task automatic run_frame(input int L, input bit garbage);
    int cyc, n;
    bit seen_done;
    for (int t = 0; t < L; t++) begin
      @(negedge clk);
      dec_valid = 1; dec_bits = fr[t]; frame_end = (t == L - 1);
    end
    @(negedge clk);
    dec_valid = 0; frame_end = 0;
    cyc = 1; n = 0; seen_done = 0;
    check(busy == 1, "R7 busy after last step", busy, 1);
    while (!seen_done && cyc < 4*MS + 20) begin
      if (garbage && cyc <= 3) begin
        dec_valid = 1; frame_end = 1; dec_bits = rnd_vec();
      end else begin
        dec_valid = 0; frame_end = 0;
      end
      if (out_valid) begin
        if (n == 0) check(cyc == L + 1, "R8 first output latency", cyc, L + 1);
        if (n < L - MB) check(out_bit == exp_b[n], "R4 R5 decoded bit", out_bit, exp_b[n]);
        n++;
      end
      if (done) begin
        seen_done = 1;
        check(cyc == 2*L - 7, "R8 done latency", cyc, 2*L - 7);
        check(n == L - MB, "R5 output count", n, L - MB);
        check(path_err == exp_err, "R6 path_err", path_err, exp_err);
        check(busy == 0, "R7 busy low at done", busy, 0);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    dec_valid = 0; frame_end = 0;
    check(seen_done, "R6 done seen", seen_done, 1);
    @(negedge clk);
    check(done == 0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sd;
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check(busy == 0 && out_valid == 0 && done == 0 && path_err == 0, "R1 reset outputs",
          {busy, out_valid, done, path_err}, 0);
    rst_n = 1;
    @(negedge clk);
    build_path(9);   run_frame(9, 0);    // R2 minimum frame
    build_path(64);  run_frame(64, 0);   // R2 full-size frame
    build_path(20);  run_frame(20, 1);   // R7 inputs ignored while busy
    for (int i = 0; i < 5; i++) begin
      int L = 10 + ($urandom % 55);
      build_path(L); run_frame(L, i[0]); // R3 R4 random frames
    end
    for (int i = 0; i < 3; i++) begin
      build_random(30); run_frame(30, 0); // R3 R6 arbitrary decisions
    end
    begin
      logic [MB-1:0] c = '0;
      build_path(16);
      fr[15][0] = 1'b1;                   // R6 forced divergence from state 0
      for (int k = 15; k >= 0; k--) begin
        exp_b[k] = c[MB-1];
        c = {c[MB-2:0], fr[k][c]};
      end
      exp_err = (c != '0);
      run_frame(16, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule